// File: doc/BRIEF.md
# Frame Loopback Engine with Destination Rewrite

The block receives whole frames on a 16-bit pipelined Wishbone streaming sink, stores their data words in a data FIFO and records each frame's word count in a separate length FIFO once the frame has closed. A transmit machine replays each stored frame on a matching streaming source. It starts a frame only after that frame has fully arrived, and it sends exactly the recorded number of words. When the rewrite option is on, the first three data words leaving the block carry a programmed 48-bit destination address. The buffered copy is not altered.

A 32-bit pipelined Wishbone register slave holds the control bits, the programmed address and three frame counters: accepted, discarded and forwarded. Each counter can be read and can be loaded from the bus, and a control write can zero all three at once. Before it stores a frame, the sink checks at the frame's first cycle that a worst-case frame still fits. If it does not, the whole frame is thrown away. Because of this check the sink never has to stall.

Top module: `pkt_loopback`

## Requirements
- R1: After reset the source is idle (cyc and stb low), no acknowledge is pending on either port, and every register and counter reads 0.
- R2: Register slave, byte addresses decoded on address bits 4:2, with every access acknowledged one cycle after its strobe and read data valid with the acknowledge. 0x00 is control: bit 0 enables the loop, bit 2 enables the address rewrite, and bit 1 reads 0. 0x04 holds the low 32 address bits. 0x08 holds the high 16 address bits in bits 15:0, and bits 31:16 read 0. 0x0C, 0x10 and 0x14 are the accepted, discarded and forwarded counters. Byte select bit n gates write byte n.
- R3: Reads of unmapped addresses 0x18 and 0x1C are acknowledged and return 0. Writes to them are acknowledged and change no register.
- R4: The sink acknowledges every strobe one cycle later and never stalls. A frame is one interval of cyc high, and consecutive frames are separated by at least one cycle with cyc low. Only write words with address 00 are stored. Words with other addresses are acknowledged and dropped.
- R5: Each accepted frame is replayed in arrival order inside one source cyc interval, with its stored data and byte selects unchanged, address 00 and we high. Transmission starts only after the frame's cyc has fallen on the sink.
- R6: With the rewrite enabled, source words 0, 1 and 2 of a frame carry address bits 47:32, 31:16 and 15:0, so a high value of 0x1122 and a low value of 0x33445566 give 11:22:33:44:55:66 on the wire. Byte selects and all later words are unchanged.
- R7: When a frame opens, it is discarded if the free data FIFO space is less than MAX_FRAME_WORDS or the length FIFO is full. A discarded frame is never sent, and it increments the discarded counter at its end.
- R8: The accepted counter increments once at the end of each stored frame.
- R9: The forwarded counter increments when the last word of a frame is acknowledged on the source.
- R10: Writing a counter loads it with the written value. Writing control with bit 1 set zeroes all three counters one cycle after the write's strobe. Counters wrap from all ones to 0.
- R11: While the loop is disabled, sink frames are still acknowledged but are neither stored, counted nor sent, and the source starts no frame.
- R12: While the source stalls, stb stays high and data and selects hold. Random stalls do not change the replayed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snk_cyc | input | 1 | Sink frame cycle |
| snk_stb | input | 1 | Sink word strobe |
| snk_we | input | 1 | Sink write enable |
| snk_sel | input | DATA_W/8 | Sink byte selects |
| snk_adr | input | 2 | Sink word kind (00 = data) |
| snk_dat | input | DATA_W | Sink data |
| snk_ack | output | 1 | Sink acknowledge |
| snk_stall | output | 1 | Sink stall (always 0) |
| src_cyc | output | 1 | Source frame cycle |
| src_stb | output | 1 | Source word strobe |
| src_we | output | 1 | Source write enable |
| src_sel | output | DATA_W/8 | Source byte selects |
| src_adr | output | 2 | Source word kind |
| src_dat | output | DATA_W | Source data |
| src_ack | input | 1 | Source acknowledge |
| src_stall | input | 1 | Source stall |
| wb_cyc | input | 1 | Register bus cycle |
| wb_stb | input | 1 | Register bus strobe |
| wb_we | input | 1 | Register bus write enable |
| wb_sel | input | 4 | Register bus byte selects |
| wb_adr | input | WB_ADDR_W | Register byte address |
| wb_dat_i | input | 32 | Register write data |
| wb_dat_o | output | 32 | Register read data |
| wb_ack | output | 1 | Register bus acknowledge |
| wb_stall | output | 1 | Register bus stall (always 0) |

## Verification
The bench sweeps every frame length from one word up to the small maximum, once with the rewrite off and once with it on, while the source stalls at random. A wrong word count or a premature start would show up as truncated, merged or corrupted frames, and frames shorter than three words exercise the partial rewrite. It holds the source stalled so that the data FIFO and then the length FIFO fill. A wrong admission rule would overflow a FIFO or forward a frame that should have been discarded. It also checks that the sink stays silent while the loop is disabled, that a forwarded counter loaded with all ones wraps to 0, that byte-lane writes and unmapped addresses behave as specified, and that the clear bit zeroes all counters yet reads back 0.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_KEEP,
    RX_SKIP,
    RX_DROP
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SEND,
    TX_DRAIN
  } tx_state_e;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_ADDR_L = 3'd1;
  localparam logic [2:0] REG_ADDR_H = 3'd2;
  localparam logic [2:0] REG_CNT0   = 3'd3;
  localparam int         NUM_CNT    = 3;

  localparam logic [1:0] WORD_DATA  = 2'b00;

endpackage

// File: rtl/lbk_fifo.sv
module lbk_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    wp_q, rp_q, wp_nxt, rp_nxt;

  always_comb begin
    wp_nxt = wp_q + CW'(wr_en);
    rp_nxt = rp_q + CW'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_nxt;
      rp_q <= rp_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wp_q[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rp_q[AW-1:0]];
  assign count   = wp_q - rp_q;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  // R7: admission control must keep writes away from a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full));

  // R5: replay pops only words that are stored
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && empty));

endmodule

// File: rtl/lbk_rx.sv
module lbk_rx
  import lbk_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEL_W     = 2,
  parameter int LEN_W     = 10,
  parameter int FREE_W    = 11,
  parameter int MAX_WORDS = 760
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      snk_cyc,
  input  logic                      snk_stb,
  input  logic                      snk_we,
  input  logic [SEL_W-1:0]          snk_sel,
  input  logic [1:0]                snk_adr,
  input  logic [DATA_W-1:0]         snk_dat,
  output logic                      snk_ack,
  output logic                      snk_stall,
  input  logic [FREE_W-1:0]         data_free,
  input  logic                      len_full,
  output logic                      data_wr,
  output logic [SEL_W+DATA_W-1:0]   data_wdata,
  output logic                      len_wr,
  output logic [LEN_W-1:0]          len_wdata,
  output logic                      rcv_inc,
  output logic                      drp_inc
);

  rx_state_e        state_q, state_nxt, mode;
  logic [LEN_W-1:0] len_q, len_nxt;
  logic             ack_q, ack_nxt;
  logic             admit, take, frame_end;

  always_comb begin
    admit = enable && (data_free >= FREE_W'(MAX_WORDS)) && !len_full;
    if (state_q != RX_IDLE) begin
      mode = state_q;
    end else if (!enable) begin
      mode = RX_SKIP;
    end else if (admit) begin
      mode = RX_KEEP;
    end else begin
      mode = RX_DROP;
    end
    take      = snk_cyc && snk_stb && snk_we && (snk_adr == WORD_DATA);
    data_wr   = take && (mode == RX_KEEP);
    frame_end = (state_q != RX_IDLE) && !snk_cyc;
  end

  always_comb begin
    state_nxt = state_q;
    len_nxt   = len_q;
    ack_nxt   = snk_cyc && snk_stb;
    if (state_q == RX_IDLE) begin
      len_nxt = LEN_W'(data_wr);
      if (snk_cyc) begin
        state_nxt = mode;
      end
    end else begin
      len_nxt = len_q + LEN_W'(data_wr);
      if (!snk_cyc) begin
        state_nxt = RX_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      len_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      len_q   <= len_nxt;
      ack_q   <= ack_nxt;
    end
  end

  assign data_wdata = {snk_sel, snk_dat};
  assign len_wdata  = len_q;
  assign len_wr     = frame_end && (state_q == RX_KEEP) && (len_q != '0);
  assign rcv_inc    = frame_end && (state_q == RX_KEEP);
  assign drp_inc    = frame_end && (state_q == RX_DROP);
  assign snk_ack    = ack_q;
  assign snk_stall  = 1'b0;

  // R4: every sink strobe is answered on the next cycle
  p_sink_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_cyc && snk_stb) |=> snk_ack);

  // R7: a discarded frame writes nothing
  p_drop_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DROP) |-> !data_wr);

  // R7: a stored frame never exceeds the reserved room
  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_KEEP) |-> (len_q <= LEN_W'(MAX_WORDS)));

  // R11: while disabled nothing is stored
  p_off_no_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_SKIP) |-> !data_wr);

endmodule

// File: rtl/lbk_tx.sv
module lbk_tx
  import lbk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter int LEN_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     rewrite,
  input  logic [47:0]              dest_addr,
  input  logic                     len_empty,
  input  logic [LEN_W-1:0]         len_rdata,
  output logic                     len_rd,
  input  logic [SEL_W+DATA_W-1:0]  data_rdata,
  output logic                     data_rd,
  output logic                     src_cyc,
  output logic                     src_stb,
  output logic                     src_we,
  output logic [SEL_W-1:0]         src_sel,
  output logic [1:0]               src_adr,
  output logic [DATA_W-1:0]        src_dat,
  input  logic                     src_ack,
  input  logic                     src_stall,
  output logic                     fwd_inc
);

  localparam int ADDR_WORDS = 48 / DATA_W;

  tx_state_e        state_q, state_nxt;
  logic [LEN_W-1:0] len_q, len_nxt, sent_q, sent_nxt, acked_q, acked_nxt;
  logic             fire;
  logic [DATA_W-1:0] addr_word;
  logic             addr_hit;

  always_comb begin
    state_nxt = state_q;
    len_nxt   = len_q;
    sent_nxt  = sent_q;
    acked_nxt = acked_q;
    len_rd    = 1'b0;
    data_rd   = 1'b0;
    fwd_inc   = 1'b0;
    fire      = (state_q == TX_SEND) && !src_stall;
    unique case (state_q)
      TX_IDLE: begin
        if (enable && !len_empty) begin
          len_rd    = 1'b1;
          len_nxt   = len_rdata;
          sent_nxt  = '0;
          acked_nxt = '0;
          state_nxt = TX_SEND;
        end
      end
      TX_SEND: begin
        if (fire) begin
          data_rd  = 1'b1;
          sent_nxt = sent_q + LEN_W'(1);
          if (sent_q == len_q - LEN_W'(1)) begin
            state_nxt = TX_DRAIN;
          end
        end
        if (src_ack) begin
          acked_nxt = acked_q + LEN_W'(1);
        end
      end
      TX_DRAIN: begin
        if (src_ack) begin
          if (acked_q == len_q - LEN_W'(1)) begin
            fwd_inc   = 1'b1;
            state_nxt = TX_IDLE;
          end else begin
            acked_nxt = acked_q + LEN_W'(1);
          end
        end
      end
      default: state_nxt = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      len_q   <= '0;
      sent_q  <= '0;
      acked_q <= '0;
    end else begin
      state_q <= state_nxt;
      len_q   <= len_nxt;
      sent_q  <= sent_nxt;
      acked_q <= acked_nxt;
    end
  end

  always_comb begin
    addr_word = '0;
    addr_hit  = 1'b0;
    for (int i = 0; i < ADDR_WORDS; i++) begin
      if (sent_q == LEN_W'(i)) begin
        addr_word = dest_addr[48-DATA_W*(i+1) +: DATA_W];
        addr_hit  = 1'b1;
      end
    end
  end

  assign src_cyc = (state_q != TX_IDLE);
  assign src_stb = (state_q == TX_SEND);
  assign src_we  = 1'b1;
  assign src_adr = WORD_DATA;
  assign src_sel = data_rdata[SEL_W+DATA_W-1:DATA_W];
  assign src_dat = (rewrite && addr_hit) ? addr_word : data_rdata[DATA_W-1:0];

  // R12: a stalled word is held unchanged
  p_hold_on_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stb && src_stall) |=> (src_stb && $stable(src_dat) && $stable(src_sel)));

  // R5: strobes only inside a frame cycle
  p_stb_in_cyc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_stb |-> src_cyc);

  // R5: never send more words than recorded
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SEND) |-> (sent_q < len_q));

  // R9: forwarded count moves only on a source acknowledge
  p_fwd_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_inc |-> src_ack);

endmodule

// File: rtl/lbk_regs.sv
module lbk_regs
  import lbk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [3:0]        wb_sel,
  input  logic [ADDR_W-1:0] wb_adr,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack,
  output logic              wb_stall,
  output logic              enable,
  output logic              rewrite,
  output logic [47:0]       dest_addr,
  input  logic [NUM_CNT-1:0] cnt_inc
);

  logic        acc, wr;
  logic [2:0]  idx;
  logic        en_q, en_nxt, rw_q, rw_nxt, clr_q, clr_nxt, ack_q;
  logic [15:0] hi_q, hi_nxt;
  logic [31:0] lo_q, lo_nxt, rd_q, rd_nxt, rd_mux;
  logic [31:0] cnt_q [NUM_CNT];
  logic [31:0] cnt_nxt [NUM_CNT];
  logic        lbk_unused;

  function automatic logic [31:0] merge(input logic [31:0] old_v,
                                        input logic [31:0] new_v,
                                        input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    end
    return r;
  endfunction

  assign acc        = wb_cyc && wb_stb;
  assign wr         = acc && wb_we;
  assign idx        = wb_adr[4:2];
  assign lbk_unused = ^{wb_adr[1:0], wb_adr};

  always_comb begin
    en_nxt  = en_q;
    rw_nxt  = rw_q;
    hi_nxt  = hi_q;
    lo_nxt  = lo_q;
    clr_nxt = 1'b0;
    if (wr && (idx == REG_CTRL) && wb_sel[0]) begin
      en_nxt  = wb_dat_i[0];
      clr_nxt = wb_dat_i[1];
      rw_nxt  = wb_dat_i[2];
    end
    if (wr && (idx == REG_ADDR_H)) begin
      hi_nxt = merge({16'h0, hi_q}, wb_dat_i, wb_sel)[15:0];
    end
    if (wr && (idx == REG_ADDR_L)) begin
      lo_nxt = merge(lo_q, wb_dat_i, wb_sel);
    end
    for (int k = 0; k < NUM_CNT; k++) begin
      if (clr_q) begin
        cnt_nxt[k] = '0;
      end else if (wr && (idx == REG_CNT0 + 3'(k))) begin
        cnt_nxt[k] = merge(cnt_q[k], wb_dat_i, wb_sel);
      end else if (cnt_inc[k]) begin
        cnt_nxt[k] = cnt_q[k] + 32'd1;
      end else begin
        cnt_nxt[k] = cnt_q[k];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      REG_CTRL:   rd_mux = {29'h0, rw_q, 1'b0, en_q};
      REG_ADDR_L: rd_mux = lo_q;
      REG_ADDR_H: rd_mux = {16'h0, hi_q};
      default: begin
        for (int k = 0; k < NUM_CNT; k++) begin
          if (idx == REG_CNT0 + 3'(k)) begin
            rd_mux = cnt_q[k];
          end
        end
      end
    endcase
    rd_nxt = acc ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rw_q  <= 1'b0;
      clr_q <= 1'b0;
      ack_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      rd_q  <= '0;
      for (int k = 0; k < NUM_CNT; k++) begin
        cnt_q[k] <= '0;
      end
    end else begin
      en_q  <= en_nxt;
      rw_q  <= rw_nxt;
      clr_q <= clr_nxt;
      ack_q <= acc;
      hi_q  <= hi_nxt;
      lo_q  <= lo_nxt;
      rd_q  <= rd_nxt;
      for (int k = 0; k < NUM_CNT; k++) begin
        cnt_q[k] <= cnt_nxt[k];
      end
    end
  end

  assign wb_dat_o  = rd_q;
  assign wb_ack    = ack_q;
  assign wb_stall  = 1'b0;
  assign enable    = en_q;
  assign rewrite   = rw_q;
  assign dest_addr = {hi_q, lo_q};

  // R2: each access is acknowledged on the next cycle
  p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> wb_ack);

  // R3: unmapped reads return zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wb_we && (idx > 3'd5)) |=> (wb_dat_o == 32'h0));

  // R10: clear leaves all counters at zero
  p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> ((cnt_q[0] == '0) && (cnt_q[1] == '0) && (cnt_q[2] == '0)));

  // R10: a full-word write loads the accepted counter
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (idx == REG_CNT0) && (wb_sel == 4'hF) && !clr_q) |=> (cnt_q[0] == $past(wb_dat_i)));

endmodule

// File: rtl/pkt_loopback.sv
module pkt_loopback
  import lbk_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int DATA_DEPTH      = 1024,
  parameter int LEN_DEPTH       = 16,
  parameter int MAX_FRAME_WORDS = 760,
  parameter int WB_ADDR_W       = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snk_cyc,
  input  logic                   snk_stb,
  input  logic                   snk_we,
  input  logic [DATA_W/8-1:0]    snk_sel,
  input  logic [1:0]             snk_adr,
  input  logic [DATA_W-1:0]      snk_dat,
  output logic                   snk_ack,
  output logic                   snk_stall,
  output logic                   src_cyc,
  output logic                   src_stb,
  output logic                   src_we,
  output logic [DATA_W/8-1:0]    src_sel,
  output logic [1:0]             src_adr,
  output logic [DATA_W-1:0]      src_dat,
  input  logic                   src_ack,
  input  logic                   src_stall,
  input  logic                   wb_cyc,
  input  logic                   wb_stb,
  input  logic                   wb_we,
  input  logic [3:0]             wb_sel,
  input  logic [WB_ADDR_W-1:0]   wb_adr,
  input  logic [31:0]            wb_dat_i,
  output logic [31:0]            wb_dat_o,
  output logic                   wb_ack,
  output logic                   wb_stall
);

  localparam int SEL_W  = DATA_W / 8;
  localparam int WORD_W = SEL_W + DATA_W;
  localparam int LEN_W  = $clog2(MAX_FRAME_WORDS + 1);
  localparam int CW     = $clog2(DATA_DEPTH) + 1;
  localparam int LCW    = $clog2(LEN_DEPTH) + 1;

  logic              enable, rewrite;
  logic [47:0]       dest_addr;
  logic              rcv_inc, drp_inc, fwd_inc;
  logic              d_wr, d_rd, d_empty, d_full;
  logic [WORD_W-1:0] d_wdata, d_rdata;
  logic [CW-1:0]     d_count, d_free;
  logic              l_wr, l_rd, l_empty, l_full;
  logic [LEN_W-1:0]  l_wdata, l_rdata;
  logic [LCW-1:0]    l_count;
  logic              lbk_unused_flags;

  assign d_free           = CW'(DATA_DEPTH) - d_count;
  assign lbk_unused_flags = ^{d_empty, d_full, l_count};

  lbk_regs #(.ADDR_W(WB_ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_sel    (wb_sel),
    .wb_adr    (wb_adr),
    .wb_dat_i  (wb_dat_i),
    .wb_dat_o  (wb_dat_o),
    .wb_ack    (wb_ack),
    .wb_stall  (wb_stall),
    .enable    (enable),
    .rewrite   (rewrite),
    .dest_addr (dest_addr),
    .cnt_inc   ({fwd_inc, drp_inc, rcv_inc})
  );

  lbk_rx #(
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W),
    .LEN_W     (LEN_W),
    .FREE_W    (CW),
    .MAX_WORDS (MAX_FRAME_WORDS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .snk_cyc    (snk_cyc),
    .snk_stb    (snk_stb),
    .snk_we     (snk_we),
    .snk_sel    (snk_sel),
    .snk_adr    (snk_adr),
    .snk_dat    (snk_dat),
    .snk_ack    (snk_ack),
    .snk_stall  (snk_stall),
    .data_free  (d_free),
    .len_full   (l_full),
    .data_wr    (d_wr),
    .data_wdata (d_wdata),
    .len_wr     (l_wr),
    .len_wdata  (l_wdata),
    .rcv_inc    (rcv_inc),
    .drp_inc    (drp_inc)
  );

  lbk_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (d_wr),
    .wr_data (d_wdata),
    .rd_en   (d_rd),
    .rd_data (d_rdata),
    .empty   (d_empty),
    .full    (d_full),
    .count   (d_count)
  );

  lbk_fifo #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_len_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (l_wr),
    .wr_data (l_wdata),
    .rd_en   (l_rd),
    .rd_data (l_rdata),
    .empty   (l_empty),
    .full    (l_full),
    .count   (l_count)
  );

  lbk_tx #(.DATA_W(DATA_W), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .rewrite    (rewrite),
    .dest_addr  (dest_addr),
    .len_empty  (l_empty),
    .len_rdata  (l_rdata),
    .len_rd     (l_rd),
    .data_rdata (d_rdata),
    .data_rd    (d_rd),
    .src_cyc    (src_cyc),
    .src_stb    (src_stb),
    .src_we     (src_we),
    .src_sel    (src_sel),
    .src_adr    (src_adr),
    .src_dat    (src_dat),
    .src_ack    (src_ack),
    .src_stall  (src_stall),
    .fwd_inc    (fwd_inc)
  );

endmodule

// File: tb/pkt_loopback_bench.sv
`timescale 1ns/1ps
module pkt_loopback_bench;

  localparam int DW   = 16;
  localparam int MAXW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          snk_cyc = 0, snk_stb = 0, snk_we = 0;
  logic [1:0]    snk_sel = 0, snk_adr = 0;
  logic [DW-1:0] snk_dat = 0;
  logic          snk_ack, snk_stall;
  logic          src_cyc, src_stb, src_we;
  logic [1:0]    src_sel, src_adr;
  logic [DW-1:0] src_dat;
  logic          src_ack = 0, src_stall = 0;
  logic          wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [3:0]    wb_sel = 0;
  logic [4:0]    wb_adr = 0;
  logic [31:0]   wb_dat_i = 0;
  logic [31:0]   wb_dat_o;
  logic          wb_ack, wb_stall;

  pkt_loopback #(
    .DATA_W(DW), .DATA_DEPTH(32), .LEN_DEPTH(4), .MAX_FRAME_WORDS(MAXW), .WB_ADDR_W(5)
  ) u_pkt_loopback (
    .clk(clk), .rst_n(rst_n),
    .snk_cyc(snk_cyc), .snk_stb(snk_stb), .snk_we(snk_we), .snk_sel(snk_sel),
    .snk_adr(snk_adr), .snk_dat(snk_dat), .snk_ack(snk_ack), .snk_stall(snk_stall),
    .src_cyc(src_cyc), .src_stb(src_stb), .src_we(src_we), .src_sel(src_sel),
    .src_adr(src_adr), .src_dat(src_dat), .src_ack(src_ack), .src_stall(src_stall),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel), .wb_adr(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack), .wb_stall(wb_stall)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_snk_stb = 0;
  int n_snk_ack = 0;
  bit stall_seen = 0;
  bit bad_word = 0;
  bit hold_stall = 0;
  bit rand_stall = 0;
  bit force_on = 0;
  logic [15:0] mac_hi = 16'h1122;
  logic [31:0] mac_lo = 32'h33445566;

  logic [17:0] exp_w[$];
  int          exp_len[$];
  logic [17:0] got_w[$];
  int          got_len[$];
  int          cur_len = 0;
  bit          pend = 0;
  bit          cyc_prev = 0;
  int          exp_rcv = 0, exp_drp = 0, exp_fwd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Source-side model: random or held stall, acknowledge one cycle after acceptance
  always @(negedge clk) begin
    if (!rst_n) begin
      src_ack = 0; src_stall = 0; pend = 0; cyc_prev = 0; cur_len = 0;
    end else begin
      bit st;
      src_ack = pend;
      st = hold_stall ? 1'b1 : (rand_stall ? ($urandom % 4 == 0) : 1'b0);
      src_stall = st;
      pend = src_cyc && src_stb && !st;
      if (pend) begin
        got_w.push_back({src_sel, src_dat});
        cur_len++;
        if (src_adr != 2'b00 || !src_we) bad_word = 1;
      end
      if (cyc_prev && !src_cyc) begin
        got_len.push_back(cur_len);
        cur_len = 0;
      end
      cyc_prev = src_cyc;
      if (snk_ack) n_snk_ack++;
      if (snk_stall) stall_seen = 1;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wb_xfer(input bit we, input logic [4:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [31:0] rd, output bit ack);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_dat_i = d; wb_sel = be;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    ack = wb_ack;
    rd  = wb_dat_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string req);
    logic [31:0] rd; bit ack;
    wb_xfer(1, a, d, 4'hF, rd, ack);
    chk(ack, req, "write ack", ack, 1);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] expv,
                        input string req, input string what);
    logic [31:0] rd; bit ack;
    wb_xfer(0, a, 32'h0, 4'hF, rd, ack);
    chk(ack && rd == expv, req, what, {ack, rd}, {1'b1, expv});
  endtask

  function automatic logic [15:0] mac_word(int i);
    if (i == 0) return mac_hi;
    if (i == 1) return mac_lo[31:16];
    return mac_lo[15:0];
  endfunction

  task automatic send_frame(input int len, input int tag, input bit status_word,
                            input bit keep);
    @(negedge clk);
    snk_cyc = 1;
    if (status_word) begin
      snk_stb = 1; snk_we = 1; snk_adr = 2'b01; snk_dat = 16'hBEEF; snk_sel = 2'b11;
      n_snk_stb++;
      @(negedge clk);
    end
    for (int i = 0; i < len; i++) begin
      logic [1:0]  s;
      logic [15:0] d;
      s = (i == len - 1 && len % 3 == 0) ? 2'b10 : 2'b11;
      d = {tag[7:0], 8'(i)};
      snk_stb = 1; snk_we = 1; snk_adr = 2'b00; snk_dat = d; snk_sel = s;
      n_snk_stb++;
      if (keep) exp_w.push_back({s, (force_on && i < 3) ? mac_word(i) : d});
      @(negedge clk);
    end
    snk_stb = 0; snk_cyc = 0; snk_we = 0;
    if (keep) exp_len.push_back(len);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_frames(input int n, input string req);
    int t = 0;
    while (got_len.size() < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(got_len.size() == n, req, "frames seen", got_len.size(), n);
    while (got_len.size() > 0 && exp_len.size() > 0) begin
      int gl, el;
      bit ok = 1;
      logic [17:0] gw, ew;
      gl = got_len.pop_front();
      el = exp_len.pop_front();
      chk(gl == el, req, "frame length", gl, el);
      for (int i = 0; i < el; i++) begin
        gw = (got_w.size() > 0) ? got_w.pop_front() : 18'h3FFFF;
        ew = exp_w.pop_front();
        if (gw != ew && ok) begin
          ok = 0;
          chk(0, req, $sformatf("word %0d", i), gw, ew);
        end
      end
      if (ok) chk(1, req, "frame words", 0, 0);
    end
    got_len.delete();
  endtask

  task automatic check_counters(input string req);
    rd_chk(5'h0C, exp_rcv, req, "accepted counter (R8)");
    rd_chk(5'h10, exp_drp, req, "discarded counter (R7)");
    rd_chk(5'h14, exp_fwd, req, "forwarded counter (R9)");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!src_cyc && !src_stb, "R1", "source idle", {src_cyc, src_stb}, 0);
    chk(!snk_ack && !wb_ack, "R1", "no pending ack", {snk_ack, wb_ack}, 0);
    rd_chk(5'h00, 0, "R1", "control after reset");
    rd_chk(5'h04, 0, "R1", "low address after reset");
    rd_chk(5'h08, 0, "R1", "high address after reset");
    check_counters("R1");

    // R2: register map and byte lanes
    wr(5'h00, 32'h7, "R2");
    rd_chk(5'h00, 32'h5, "R2", "control bit 1 reads 0");
    wr(5'h00, 32'h0, "R2");
    wr(5'h08, 32'hFFFF1122, "R2");
    rd_chk(5'h08, 32'h00001122, "R2", "high address 16 bits");
    wr(5'h04, 32'h33445566, "R2");
    begin
      logic [31:0] rd; bit ack;
      wb_xfer(1, 5'h04, 32'hAAAAAAAA, 4'b0001, rd, ack);
      chk(ack, "R2", "byte write ack", ack, 1);
    end
    rd_chk(5'h04, 32'h334455AA, "R2", "byte lane write");
    wr(5'h04, 32'h33445566, "R2");
    // R3: unmapped addresses
    rd_chk(5'h18, 0, "R3", "unmapped read 0x18");
    wr(5'h1C, 32'hFFFFFFFF, "R3");
    rd_chk(5'h1C, 0, "R3", "unmapped read 0x1C");
    rd_chk(5'h00, 0, "R3", "control untouched by unmapped write");

    // R5 / R12: length sweep, rewrite off, random stalls
    rand_stall = 1;
    wr(5'h00, 32'h1, "R5");
    force_on = 0;
    for (int l = 1; l <= MAXW; l++) begin
      send_frame(l, l, (l % 2 == 0), 1);
      exp_rcv++; exp_fwd++;
      expect_frames(1, "R5");
    end
    // R6: length sweep with rewrite
    wr(5'h00, 32'h5, "R6");
    force_on = 1;
    for (int l = 1; l <= MAXW; l++) begin
      send_frame(l, 8'h80 + l, (l % 3 == 0), 1);
      exp_rcv++; exp_fwd++;
      expect_frames(1, "R6");
    end
    check_counters("R12");
    chk(!bad_word, "R5", "source address and we", bad_word, 0);

    // R7: data FIFO room exhausted
    hold_stall = 1;
    send_frame(MAXW, 8'hA1, 0, 1);
    send_frame(MAXW, 8'hA2, 0, 1);
    send_frame(MAXW, 8'hA3, 0, 0);
    exp_rcv += 2; exp_drp += 1;
    chk(got_len.size() == 0, "R5", "no frame while stalled", got_len.size(), 0);
    hold_stall = 0;
    exp_fwd += 2;
    expect_frames(2, "R7");
    check_counters("R7");

    // R7: length FIFO full
    hold_stall = 1;
    for (int f = 0; f < 5; f++) send_frame(1, 8'hC0 + f, 0, 1);
    send_frame(1, 8'hCF, 0, 0);
    exp_rcv += 5; exp_drp += 1;
    hold_stall = 0;
    exp_fwd += 5;
    expect_frames(5, "R7");
    check_counters("R7");

    // R11: disabled loop
    wr(5'h00, 32'h4, "R11");
    send_frame(5, 8'hD0, 1, 0);
    repeat (40) @(negedge clk);
    chk(got_len.size() == 0 && !src_cyc, "R11", "nothing forwarded", got_len.size(), 0);
    check_counters("R11");

    // R10: load, wrap and clear
    wr(5'h0C, 32'h12345678, "R10");
    rd_chk(5'h0C, 32'h12345678, "R10", "accepted counter load");
    wr(5'h14, 32'hFFFFFFFF, "R10");
    wr(5'h00, 32'h1, "R10");
    force_on = 0;
    send_frame(4, 8'hE0, 0, 1);
    expect_frames(1, "R10");
    rd_chk(5'h14, 32'h0, "R10", "forwarded counter wraps");
    rd_chk(5'h0C, 32'h12345679, "R8", "accepted after load");
    wr(5'h00, 32'h3, "R10");
    rd_chk(5'h0C, 0, "R10", "accepted cleared");
    rd_chk(5'h10, 0, "R10", "discarded cleared");
    rd_chk(5'h14, 0, "R10", "forwarded cleared");
    rd_chk(5'h00, 32'h1, "R10", "clear bit reads 0");

    // R4: sink handshake
    repeat (3) @(negedge clk);
    chk(n_snk_ack == n_snk_stb, "R4", "sink acks per strobe", n_snk_ack, n_snk_stb);
    chk(!stall_seen, "R4", "sink never stalls", stall_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule